// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves fixed 8-bit characters. A character is written into a transmit holding register. It is shifted out on `ser_out`, least significant bit first. A character arriving on `ser_in` is assembled into a receive holding register at the same time. The serial clock can come from either of two sources. One is an internal divider, which drives the clock out on the clock pin. The other is an external clock input, which first passes through a synchronizer.

The internal clock rests high. Each character gets exactly eight low pulses. The half-period is `clk_div + 1` system clock cycles. Receive data is sampled on each falling serial edge, and transmit data moves on each rising edge. When the transmitter is off and the receiver is on, the internal clock free-runs character after character. After a character, the data line keeps the level of the last bit that was sent. Three status outputs report the buffers: `tx_empty`, `rx_full` and `rx_overrun`.

Top module: `sync_serial_port`

## Requirements
- R1: A character is sent as 8 bits, bit 0 first and bit 7 last, with no parity or extra bit. Each bit is valid at the falling serial edge that the peer samples.
- R2: When a character ends and no new one follows, `ser_out` stays at the level of bit 7 for as long as `tx_enable` stays 1.
- R3: `ser_in` is sampled once per falling serial edge and assembled bit 0 first. After the 8th sample, `rx_data` holds the character and `rx_full` goes to 1.
- R4: When `use_int_clk` is 1, `sck_oe` is 1 and `sck_out` is high whenever no character is in progress. Each character produces exactly 8 low pulses.
- R5: When `use_int_clk` is 1 and `clk_div` is 1 or more, each low phase and each high phase of `sck_out` lasts `clk_div + 1` system clock cycles.
- R6: When `use_int_clk` is 0, `sck_oe` is 0 and `sck_out` is 1. Shifting follows the edges of `sck_in`: falling edges sample and rising edges shift.
- R7: When `use_int_clk` is 1, `tx_enable` is 0 and `rx_enable` is 1, the clock runs one character after another. Once `rx_enable` drops, the clock completes the current character and then stays high.
- R8: While `tx_enable` is 0, `tx_empty` is 1, writes are discarded and `ser_out` is 1. Clearing `tx_enable` in the middle of a character abandons that character.
- R9: While `rx_enable` is 0, `rx_full`, `rx_overrun` and `rx_data` keep their values. The exceptions are an explicit read, which clears `rx_full`, and an overrun clear, which clears `rx_overrun`.
- R10: If a character completes while `rx_full` is 1 and no read happens in that cycle, `rx_overrun` is set, the new character is dropped and `rx_data` is unchanged.
- R11: Pulsing `rx_read` clears `rx_full`, and pulsing `ovr_clear` clears `rx_overrun`. After reset, `tx_empty` is 1, `rx_full` is 0, `rx_overrun` is 0 and `ser_out` is 1.
- R12: During a character, `ser_out` changes only on the system cycle after a rising serial edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_int_clk | input | 1 | 1: internal divider drives the clock; 0: external clock input |
| clk_div | input | DIV_W | Divider reload value; half-period is clk_div+1 cycles |
| tx_enable | input | 1 | Transmitter enable |
| rx_enable | input | 1 | Receiver enable |
| tx_write | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Character to transmit |
| rx_read | input | 1 | Read strobe; clears rx_full |
| ovr_clear | input | 1 | Clears rx_overrun |
| rx_data | output | 8 | Last accepted received character |
| tx_empty | output | 1 | Transmit holding register can accept a character |
| rx_full | output | 1 | rx_data holds an unread character |
| rx_overrun | output | 1 | A character was lost because rx_full was set |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Output enable of the serial clock pin |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle:
- the internal clock never produces more than eight pulses per character, and it rests high when idle;
- the falling and rising strobes never coincide;
- the data line moves only after a rising strobe, and it holds bit 7 once the transmitter is idle;
- the transmit-empty flag is forced while the transmitter is disabled;
- the received data and flags stay frozen under overrun and while the receiver is off.

Other behaviour only the bench scenarios can show. These are the bit order and the value on the line for every one of the 256 characters, the exact pulse count and half-period width for several divider settings, external-clock transfers, and the receive-only free-run. The free-run scenario also covers how the clock stops after the receiver is disabled in the middle of a character, and the overrun-and-clear sequence.

// File: rtl/ssp_pkg.sv
// Package: shared widths and types of the synchronous serial port.
// Assumes a fixed 8-bit character with no parity or extra bits.
package ssp_pkg;
    localparam int CHAR_BITS = 8;
    localparam int BIT_IDX_W = $clog2(CHAR_BITS);
    localparam int PULSE_W   = $clog2(CHAR_BITS + 1);

    typedef logic [CHAR_BITS-1:0] char_t;

    // Internal clock generator states
    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_RUN  = 2'd1,
        CG_HOLD = 2'd2
    } cg_state_e;
endpackage

// File: rtl/ssp_clkgen.sv
// Module: serial clock source.
// Internal mode: on start_req, produces CHAR_BITS low pulses with a half-period
// of div+1 cycles, idles high, then passes through one HOLD cycle before it
// can restart. External mode: synchronizes sck_in through two flops and
// detects its edges. Both modes issue one-cycle registered fall/rise strobes.
// Assumes sck_in is slow relative to clk (at least 4 cycles per phase).
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int,
    input  logic [DIV_W-1:0] div,
    input  logic             start_req,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             fall_stb,
    output logic             rise_stb
);
    cg_state_e          state;
    logic [DIV_W-1:0]   cnt;
    logic [PULSE_W-1:0] pulses;
    logic               sck_q;
    logic               sync1, sync2, sync3;

    // Synchronizer chain for the external clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            sync3 <= 1'b1;
        end else begin
            sync1 <= sck_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    // Divider, pulse counter and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CG_IDLE;
            cnt      <= '0;
            pulses   <= '0;
            sck_q    <= 1'b1;
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
            if (!use_int) begin
                state    <= CG_IDLE;
                sck_q    <= 1'b1;
                fall_stb <= sync3 & ~sync2;
                rise_stb <= ~sync3 & sync2;
            end else begin
                case (state)
                    CG_IDLE: begin
                        if (start_req) begin
                            state  <= CG_RUN;
                            cnt    <= div;
                            pulses <= '0;
                        end
                    end
                    CG_RUN: begin
                        if (cnt == '0) begin
                            cnt   <= div;
                            sck_q <= ~sck_q;
                            if (sck_q) begin
                                fall_stb <= 1'b1;
                            end else begin
                                rise_stb <= 1'b1;
                                pulses   <= pulses + 1'b1;
                                if (pulses == PULSE_W'(CHAR_BITS - 1)) begin
                                    state <= CG_HOLD;
                                end
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: state <= CG_IDLE;
                endcase
            end
        end
    end

    assign sck_out = sck_q;

    // R4
    pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PULSE_W'(CHAR_BITS));
    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_int && state == CG_IDLE) |-> sck_out);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb}));
endmodule

// File: rtl/ssp_tx.sv
// Module: transmit holding register and shifter.
// Loads a waiting character when idle and enabled, presents bit 0 at once,
// advances one bit per rise strobe and leaves the last bit on the line.
// Disabling forces the empty flag, drops the character and drives the line high.
module ssp_tx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_en,
    input  logic  wr,
    input  char_t wdata,
    input  logic  rise_stb,
    output logic  sdo,
    output logic  empty,
    output logic  busy
);
    char_t                hold_q;
    char_t                shift_q;
    logic [BIT_IDX_W-1:0] bit_q;

    // Holding register, loading and bit shifting
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            hold_q  <= '0;
            shift_q <= '0;
            bit_q   <= '0;
            busy    <= 1'b0;
            empty   <= 1'b1;
            sdo     <= 1'b1;
        end else begin
            if (busy) begin
                if (rise_stb) begin
                    if (bit_q == BIT_IDX_W'(CHAR_BITS - 1)) begin
                        busy <= 1'b0;
                    end else begin
                        shift_q <= shift_q >> 1;
                        sdo     <= shift_q[1];
                        bit_q   <= bit_q + 1'b1;
                    end
                end
            end else if (!empty) begin
                shift_q <= hold_q;
                sdo     <= hold_q[0];
                bit_q   <= '0;
                busy    <= 1'b1;
                empty   <= 1'b1;
            end
            if (wr) begin
                hold_q <= wdata;
                empty  <= 1'b0;
            end
        end
    end

    // R8
    te_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (empty && sdo));
    // R2
    msb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_en) |=> ($stable(sdo) || busy || !tx_en));
    // R12
    tx_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rise_stb && tx_en) |=> $stable(sdo));
endmodule

// File: rtl/ssp_rx.sv
// Module: receive shifter and holding register.
// Samples the input on each fall strobe, bit 0 first; after the last bit it
// either stores the character and raises full, or flags overrun and drops it.
// Disabling only resets the bit position; data and flags are kept.
module ssp_rx
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_en,
    input  logic  fall_stb,
    input  logic  sdi,
    input  logic  rd,
    input  logic  ovr_clr,
    output char_t rdata,
    output logic  full,
    output logic  ovr
);
    char_t                shift_q;
    logic [BIT_IDX_W-1:0] bit_q;
    char_t                next_char;

    assign next_char = {sdi, shift_q[CHAR_BITS-1:1]};

    // Sampling, completion, overrun and flag clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_q   <= '0;
            rdata   <= '0;
            full    <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (rd)      full <= 1'b0;
            if (ovr_clr) ovr  <= 1'b0;
            if (!rx_en) begin
                bit_q <= '0;
            end else if (fall_stb) begin
                shift_q <= next_char;
                bit_q   <= bit_q + 1'b1;
                if (bit_q == BIT_IDX_W'(CHAR_BITS - 1)) begin
                    if (full && !rd) begin
                        ovr <= 1'b1;
                    end else begin
                        rdata <= next_char;
                        full  <= 1'b1;
                    end
                end
            end
        end
    end

    // R10
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd) |=> $stable(rdata));
    // R9
    re_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd && !ovr_clr) |=> ($stable(full) && $stable(ovr) && $stable(rdata)));
endmodule

// File: rtl/sync_serial_port.sv
// Module: top of the synchronous serial transceiver.
// Joins the clock source, transmitter and receiver. The internal clock is
// requested by a loaded transmit character, or continuously in receive-only
// mode. Assumes clk_div >= 1 for internal operation.
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int_clk,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             tx_enable,
    input  logic             rx_enable,
    input  logic             tx_write,
    input  logic [7:0]       tx_wdata,
    input  logic             rx_read,
    input  logic             ovr_clear,
    output logic [7:0]       rx_data,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             rx_overrun,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             ser_out,
    input  logic             ser_in
);
    logic fall_stb, rise_stb, tx_busy, start_req;

    // Clock request: a character in flight, or receive-only free-run
    assign start_req = tx_busy | (rx_enable & ~tx_enable);
    assign sck_oe    = use_int_clk;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_int  (use_int_clk),
        .div      (clk_div),
        .start_req(start_req),
        .sck_in   (sck_in),
        .sck_out  (sck_out),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    ssp_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_enable),
        .wr      (tx_write),
        .wdata   (tx_wdata),
        .rise_stb(rise_stb),
        .sdo     (ser_out),
        .empty   (tx_empty),
        .busy    (tx_busy)
    );

    ssp_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_enable),
        .fall_stb(fall_stb),
        .sdi     (ser_in),
        .rd      (rx_read),
        .ovr_clr (ovr_clear),
        .rdata   (rx_data),
        .full    (rx_full),
        .ovr     (rx_overrun)
    );
endmodule

// File: tb/sync_serial_port_tb.sv
// Bench: a serial peer model follows the serial clock line; it captures
// ser_out on falling edges and drives ser_in after rising edges.
module sync_serial_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int EXT_HALF   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             use_int_clk = 1'b1;
    logic [DIV_W-1:0] clk_div = 8'd1;
    logic             tx_enable = 1'b0, rx_enable = 1'b0;
    logic             tx_write = 1'b0, rx_read = 1'b0, ovr_clear = 1'b0;
    logic [7:0]       tx_wdata = '0;
    logic [7:0]       rx_data;
    logic             tx_empty, rx_full, rx_overrun;
    logic             sck_ext = 1'b1;
    logic             sck_out, sck_oe, ser_out;
    logic             ser_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Peer model state
    logic [7:0] pbytes [4];
    int         peer_bit = 0;
    logic [7:0] cap = '0;
    int         t_fall = 0;
    int         low_w = 0;

    sync_serial_port #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .use_int_clk(use_int_clk), .clk_div(clk_div),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .tx_write(tx_write),
        .tx_wdata(tx_wdata), .rx_read(rx_read), .ovr_clear(ovr_clear),
        .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .sck_in(sck_ext), .sck_out(sck_out),
        .sck_oe(sck_oe), .ser_out(ser_out), .ser_in(ser_in)
    );

    wire sck_line = use_int_clk ? sck_out : sck_ext;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // Peer: capture on falling edge
    always @(negedge sck_line) begin
        #1;
        cap    = {ser_out, cap[7:1]};
        peer_bit++;
        t_fall = cyc;
    end

    // Peer: next data bit after rising edge
    always @(posedge sck_line) begin
        #1;
        low_w  = cyc - t_fall;
        ser_in = pbytes[(peer_bit / 8) % 4][peer_bit % 8];
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peer_init(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3);
        pbytes[0] = b0; pbytes[1] = b1; pbytes[2] = b2; pbytes[3] = b3;
        peer_bit = 0;
        cap = '0;
        ser_in = b0[0];
    endtask

    task automatic write_tx(input logic [7:0] v);
        @(negedge clk);
        tx_wdata = v;
        tx_write = 1'b1;
        @(negedge clk);
        tx_write = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic wait_full();
        for (int n = 0; n < 4000 && !rx_full; n++) tick(1);
    endtask

    task automatic wait_peer(input int k);
        for (int n = 0; n < 4000 && peer_bit < k; n++) tick(1);
    endtask

    // Internal-clock full-duplex character
    task automatic xfer_int(input logic [7:0] t, input logic [7:0] r, input bit full_chk);
        peer_init(r, r, r, r);
        write_tx(t);
        wait_full();
        tick(2 * (int'(clk_div) + 1) + 6);
        chk("R1 transmitted character", cap, t);
        chk("R3 received character", rx_data, r);
        if (full_chk) begin
            chk("R4 eight pulses per character", peer_bit, 8);
            chk("R4 clock idles high", sck_out, 1);
            chk("R2 line holds bit 7", ser_out, t[7]);
            chk("R5 low phase width", low_w, int'(clk_div) + 1);
        end
        pulse_read();
        if (full_chk) chk("R11 read clears full", rx_full, 0);
    endtask

    // External-clock full-duplex character
    task automatic xfer_ext(input logic [7:0] t, input logic [7:0] r);
        peer_init(r, r, r, r);
        write_tx(t);
        tick(4);
        for (int b = 0; b < 8; b++) begin
            sck_ext = 1'b0; tick(EXT_HALF);
            sck_ext = 1'b1; tick(EXT_HALF);
        end
        chk("R6 external transmitted character", cap, t);
        chk("R6 external received character", rx_data, r);
        chk("R6 external rx_full", rx_full, 1);
        chk("R2 external line holds bit 7", ser_out, t[7]);
        pulse_read();
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pbytes[0] = '1; pbytes[1] = '1; pbytes[2] = '1; pbytes[3] = '1;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // Reset state
        chk("R11 reset tx_empty", tx_empty, 1);
        chk("R11 reset rx_full", rx_full, 0);
        chk("R11 reset rx_overrun", rx_overrun, 0);
        chk("R11 reset ser_out", ser_out, 1);
        chk("R4 reset clock high", sck_out, 1);
        chk("R4 internal drives pin", sck_oe, 1);

        // Full sweep of characters, internal clock, divider 1
        tx_enable = 1'b1; rx_enable = 1'b1; clk_div = 8'd1;
        tick(2);
        for (int v = 0; v < 256; v++) begin
            xfer_int(8'(v), 8'(v * 37 + 91), 1'b1);
        end

        // Divider sweep
        for (int d = 2; d <= 6; d++) begin
            clk_div = 8'(d);
            xfer_int(8'(d * 29 + 3), 8'(~(d * 13)), 1'b1);
            xfer_int(8'h80 | 8'(d), 8'h01, 1'b1);
        end

        // Transmitter disabled: writes discarded, mid-character abort
        clk_div = 8'd2;
        rx_enable = 1'b0;
        tx_enable = 1'b0;
        peer_init(8'h00, 8'h00, 8'h00, 8'h00);
        write_tx(8'h5A);
        tick(2);
        chk("R8 empty while disabled", tx_empty, 1);
        tx_enable = 1'b1;
        tick(100);
        chk("R8 discarded write sends nothing", peer_bit, 0);
        chk("R8 line high after disable", ser_out, 1);
        write_tx(8'hF0);
        wait_peer(3);
        tx_enable = 1'b0;
        tick(1);
        chk("R8 disable sets empty", tx_empty, 1);
        chk("R8 disable drives line high", ser_out, 1);
        tick(200);
        chk("R8 clock finishes the character", peer_bit, 8);
        chk("R4 clock high after abort", sck_out, 1);
        tx_enable = 1'b1;
        tick(200);
        chk("R8 aborted character not resent", peer_bit, 8);

        // Receive-only free-run, overrun, receiver disable
        tx_enable = 1'b0;
        clk_div = 8'd1;
        peer_init(8'h3C, 8'hA7, 8'h51, 8'hE8);
        tick(2);
        rx_enable = 1'b1;
        wait_full();
        tick(1);
        chk("R7 free-run first character", rx_data, 8'h3C);
        wait_peer(16);
        tick(4);
        chk("R10 overrun set", rx_overrun, 1);
        chk("R10 data kept on overrun", rx_data, 8'h3C);
        chk("R10 full kept on overrun", rx_full, 1);
        wait_peer(18);
        rx_enable = 1'b0;
        tick(300);
        chk("R7 clock stops after current character", peer_bit, 24);
        chk("R7 clock idles high", sck_out, 1);
        chk("R9 full kept", rx_full, 1);
        chk("R9 overrun kept", rx_overrun, 1);
        chk("R9 data kept", rx_data, 8'h3C);
        pulse_read();
        tick(1);
        chk("R11 read clears full", rx_full, 0);
        chk("R11 read leaves overrun", rx_overrun, 1);
        @(negedge clk); ovr_clear = 1'b1;
        @(negedge clk); ovr_clear = 1'b0;
        tick(1);
        chk("R11 overrun clear", rx_overrun, 0);

        // External clock
        use_int_clk = 1'b0;
        tx_enable = 1'b1;
        rx_enable = 1'b1;
        tick(4);
        chk("R6 external pin released", sck_oe, 0);
        chk("R6 internal clock parked", sck_out, 1);
        for (int i = 0; i < 16; i++) begin
            xfer_ext(8'(i * 17 + 5), 8'(~(i * 23)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule